// File: doc/BRIEF.md
# Almost-Full / Almost-Empty Offset Loader

This block holds the two threshold offsets a queue's flag logic compares against: the almost-empty offset (X) and the almost-full offset (Y). While master reset is low, a mode pin and two select pins choose how the offsets are filled. The block can load a fixed preset into both registers. It can instead take two words from the write data port. As a third choice it can shift in a serial bit stream on the writer clock. Once the load is complete, a done output goes high.

The offset width follows the queue depth: each offset is `ADDR_W + 10` bits wide, so a full serial load is `2*(ADDR_W+10)` bits. With the default `ADDR_W = 10` that is 40 bits. A partial reset leaves the method and the offsets untouched. While the partial reset is low, the block also pauses any load that is still in progress.

Top module: `offset_loader`

## Requirements
- R1: At every clock edge with `mrst_n` low and `cfg_mode` = 1, the select pins {`cfg_sel_sen_n`,`cfg_sel_sd`} = 00, 01 or 10 choose the preset method. Both offsets become 8, 16 or 64 respectively, and `load_done` is 1. All of this is visible from the edge onward.
- R2: At a master-reset edge with `cfg_mode` = 1 and both select pins at 1, the parallel method is chosen. At a master-reset edge with `cfg_mode` = 0, the serial method is chosen. In both cases the offsets are cleared to 0 and `load_done` is 0.
- R3: In the parallel method, the first clock edge with `wr_en` = 1 after release loads `wr_data[OFS_W-1:0]` into X. The second such edge loads the same bits into Y and sets `load_done`.
- R4: In the serial method, each clock edge with `cfg_sel_sen_n` = 0 shifts `cfg_sel_sd` into the register pair {Y,X} at the X LSB end. The first bit therefore ends up as the Y MSB and the last bit as the X LSB.
- R5: In the serial method, `load_done` rises at the edge that takes bit number `2*OFS_W`, and not earlier.
- R6: While `load_done` is 1 and master reset is high, data writes and serial bits leave both offsets unchanged.
- R7: While `prst_n` is low, the method, the offsets, `load_done` and the load progress are all kept, and load writes and serial bits are ignored.
- R8: The method is taken only at master-reset edges; the value sampled at the last low edge stays in force. After release the select pins no longer pick the method. In the serial method `wr_en` has no effect, and in the parallel method `cfg_sel_sen_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Writer clock |
| mrst_n | input | 1 | Master reset, active low, synchronous; chooses the method |
| prst_n | input | 1 | Partial reset, active low; keeps the settings and pauses loading |
| cfg_sel_sen_n | input | 1 | Select bit 1 during master reset; serial enable (active low) afterwards |
| cfg_sel_sd | input | 1 | Select bit 0 during master reset; serial data afterwards |
| cfg_mode | input | 1 | Mode pin: 1 gives preset or parallel, 0 gives serial |
| wr_en | input | 1 | Data port write strobe for the parallel load |
| wr_data | input | DATA_W | Data port; the low OFS_W bits are used |
| ofs_x | output | ADDR_W+10 | Almost-empty offset |
| ofs_y | output | ADDR_W+10 | Almost-full offset |
| load_done | output | 1 | Offsets fully programmed |

## Verification
Every result of this block is a register, so each effect of an input sampled at a rising edge is due right after that edge. The bench drives inputs on the falling edge. Its behavioural model steps on the rising edge, and the bench compares the offsets and `load_done` against the model on the next falling edge. Gaps, partial-reset pauses and bits offered after completion are mixed into the parallel and serial loads. Because of this, an extra or missing shift shows up in the very cycle it happens.

// File: rtl/offset_loader.sv
module offset_loader #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              cfg_sel_sen_n,
  input  logic              cfg_sel_sd,
  input  logic              cfg_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W+9:0] ofs_x,
  output logic [ADDR_W+9:0] ofs_y,
  output logic              load_done
);
  localparam int OFS_W = ADDR_W + 10;
  localparam int TOTAL = 2 * OFS_W;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [1:0] M_PRE = 2'd0, M_PAR = 2'd1, M_SER = 2'd2;

  logic [1:0]       meth;
  logic [CNT_W-1:0] cnt;
  logic [OFS_W-1:0] preset_v;
  logic             unused_hi;

  wire take    = mrst_n && prst_n && !load_done;
  wire par_wr  = take && (meth == M_PAR) && wr_en;
  wire ser_bit = take && (meth == M_SER) && !cfg_sel_sen_n;
  wire is_par  = cfg_mode && cfg_sel_sen_n && cfg_sel_sd;

  assign preset_v  = cfg_sel_sen_n ? OFS_W'(64) : (cfg_sel_sd ? OFS_W'(16) : OFS_W'(8));
  assign unused_hi = ^wr_data;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      cnt <= '0;
      if (cfg_mode && !is_par) begin
        meth <= M_PRE; ofs_x <= preset_v; ofs_y <= preset_v; load_done <= 1'b1;
      end else begin
        meth <= is_par ? M_PAR : M_SER;
        ofs_x <= '0; ofs_y <= '0; load_done <= 1'b0;
      end
    end else if (par_wr) begin
      cnt <= cnt + 1'b1;
      if (cnt == '0) ofs_x <= wr_data[OFS_W-1:0];
      else begin
        ofs_y <= wr_data[OFS_W-1:0];
        load_done <= 1'b1;
      end
    end else if (ser_bit) begin
      cnt <= cnt + 1'b1;
      {ofs_y, ofs_x} <= {ofs_y[OFS_W-2:0], ofs_x, cfg_sel_sd};
      if (cnt == CNT_W'(TOTAL - 1)) load_done <= 1'b1;
    end
  end

  a_r1_preset_pair: assert property (@(posedge clk) disable iff (!mrst_n)
    (meth == M_PRE) |-> (ofs_x == ofs_y) && load_done &&
      (ofs_x == OFS_W'(8) || ofs_x == OFS_W'(16) || ofs_x == OFS_W'(64)));

  a_r3_par_y_last: assert property (@(posedge clk) disable iff (!mrst_n)
    (meth == M_PAR) && $rose(load_done) |-> $past(wr_en) && (ofs_y == $past(wr_data[OFS_W-1:0])));

  a_r5_ser_count: assert property (@(posedge clk) disable iff (!mrst_n)
    (meth == M_SER) && $rose(load_done) |-> $past(!cfg_sel_sen_n) && ($past(cnt) == CNT_W'(TOTAL - 1)));

  a_r6_hold_done: assert property (@(posedge clk) disable iff (!mrst_n)
    mrst_n && load_done |=> $stable(ofs_x) && $stable(ofs_y) && load_done);

  a_r7_prst_hold: assert property (@(posedge clk) disable iff (!mrst_n)
    mrst_n && !prst_n |=> $stable(ofs_x) && $stable(ofs_y) && $stable(load_done) && $stable(cnt));

  a_r8_method_fixed: assert property (@(posedge clk) disable iff (!mrst_n)
    mrst_n |=> $stable(meth));
endmodule

// File: tb/sim_offset_loader.sv
module sim_offset_loader;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 36;
  localparam int OW = ADDR_W + 10;
  localparam int TOT = 2 * OW;

  logic clk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1, sen_n = 1'b1, sd = 1'b0, mode = 1'b1, wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [OW-1:0] ofs_x, ofs_y;
  logic load_done;

  int errors = 0, checks = 0;
  bit started = 0, finished = 0;
  string req = "R1";

  int m_meth, m_n;
  logic [TOT-1:0] m_cat;
  logic m_done;

  offset_loader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .cfg_sel_sen_n(sen_n), .cfg_sel_sd(sd),
    .cfg_mode(mode), .wr_en(wr_en), .wr_data(wr_data),
    .ofs_x(ofs_x), .ofs_y(ofs_y), .load_done(load_done));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    started = 1;
    if (!mrst_n) begin
      m_n = 0;
      if (mode && !(sen_n && sd)) begin
        m_meth = 0; m_done = 1;
        m_cat[OW-1:0] = sen_n ? OW'(64) : (sd ? OW'(16) : OW'(8));
        m_cat[TOT-1:OW] = m_cat[OW-1:0];
      end else begin
        m_meth = (mode) ? 1 : 2; m_done = 0; m_cat = '0;
      end
    end else if (prst_n && !m_done) begin
      if (m_meth == 1 && wr_en) begin
        if (m_n == 0) m_cat[OW-1:0] = wr_data[OW-1:0];
        else begin m_cat[TOT-1:OW] = wr_data[OW-1:0]; m_done = 1; end
        m_n++;
      end else if (m_meth == 2 && !sen_n) begin
        m_cat = {m_cat[TOT-2:0], sd};
        m_n++;
        if (m_n == TOT) m_done = 1;
      end
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started && !finished) begin
    check({req, " x"}, 64'(ofs_x), 64'(m_cat[OW-1:0]));
    check({req, " y"}, 64'(ofs_y), 64'(m_cat[TOT-1:OW]));
    check({req, " done"}, 64'(load_done), 64'(m_done));
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic do_mreset(logic m, logic a, logic b);
    mrst_n = 0; mode = m; sen_n = a; sd = b;
    repeat (5) tick();
    mrst_n = 1; sen_n = 1; sd = 0; mode = ~m;
    tick();
  endtask

  task automatic ser_bit(logic v);
    sen_n = 0; sd = v; tick(); sen_n = 1; sd = 0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    logic [TOT-1:0] pat;
    pat = {20'hA5C3F, 20'h1E2D4};
    tick();
    req = "R1";
    do_mreset(1, 0, 0);
    check("R1 preset 8", 64'(ofs_x), 64'd8);
    req = "R6";
    wr_en = 1; wr_data = 36'h12345; tick(); wr_en = 0;
    ser_bit(1); ser_bit(0);
    check("R6 preset kept", 64'(ofs_y), 64'd8);
    req = "R1";
    do_mreset(1, 0, 1);
    check("R1 preset 16", 64'(ofs_y), 64'd16);
    do_mreset(1, 1, 0);
    check("R1 preset 64", 64'(ofs_x), 64'd64);
    check("R1 preset done", 64'(load_done), 64'd1);

    req = "R2";
    do_mreset(1, 1, 1);
    check("R2 parallel cleared", 64'({ofs_y, ofs_x}), 64'd0);
    req = "R8";
    ser_bit(1); ser_bit(1); ser_bit(0);
    check("R8 serial ignored in parallel", 64'(ofs_x), 64'd0);
    req = "R3";
    wr_en = 1; wr_data = 36'hF_ABCDE; tick(); wr_en = 0;
    check("R3 x loaded", 64'(ofs_x), 64'hABCDE);
    tick();
    req = "R7";
    prst_n = 0; wr_en = 1; wr_data = 36'h7_77777; tick(); tick(); wr_en = 0; prst_n = 1;
    check("R7 y not loaded in partial reset", 64'(ofs_y), 64'd0);
    check("R7 done kept low", 64'(load_done), 64'd0);
    req = "R3";
    wr_en = 1; wr_data = 36'h0_13579; tick();
    check("R3 y loaded", 64'(ofs_y), 64'h13579);
    check("R3 done", 64'(load_done), 64'd1);
    req = "R6";
    wr_data = 36'h0_FFFFF; tick(); tick(); wr_en = 0;
    check("R6 x kept after done", 64'(ofs_x), 64'hABCDE);

    req = "R2";
    do_mreset(0, 1, 1);
    check("R2 serial cleared", 64'({ofs_y, ofs_x}), 64'd0);
    req = "R8";
    wr_en = 1; wr_data = 36'h0_55555; tick(); tick(); wr_en = 0;
    check("R8 wr ignored in serial", 64'(ofs_x), 64'd0);
    req = "R4";
    for (int i = TOT - 1; i >= 0; i--) begin
      if (i == 25) begin
        req = "R7";
        prst_n = 0; sen_n = 0; sd = 1; tick(); tick(); prst_n = 1; sen_n = 1;
        req = "R4";
      end
      if (i % 7 == 0) tick();
      if (i == 0) req = "R5";
      if (i == 1) check("R5 not done early", 64'(load_done), 64'd0);
      ser_bit(pat[i]);
    end
    check("R4 y serial", 64'(ofs_y), 64'(pat[TOT-1:OW]));
    check("R4 x serial", 64'(ofs_x), 64'(pat[OW-1:0]));
    check("R5 done after all bits", 64'(load_done), 64'd1);
    req = "R6";
    ser_bit(0); ser_bit(1); ser_bit(0);
    check("R6 serial kept", 64'(ofs_x), 64'(pat[OW-1:0]));
    req = "R7";
    prst_n = 0; tick(); tick(); prst_n = 1; tick();
    check("R7 offsets kept through partial reset", 64'(ofs_y), 64'(pat[TOT-1:OW]));
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired req=%s actual=running expected=finished", req);
      finish_run();
    end
  end
endmodule